// File: doc/BRIEF.md
# Priority interrupt level selector

This block decides which interrupt level a processor core should take next. Every cycle it combines a 16-bit vector of external level requests with the level bits of a software interrupt register. The two timer-match bits of that register do not stand for levels of their own. Either one of them makes level 14 pending.

The highest pending level that is strictly above the current processor interrupt level becomes a candidate. The candidate trap type is the external-interrupt base code with the level number in its low bits. A registered interrupt index and a hard-interrupt request flag are updated from this candidate. The update is subject to three conditions: interrupts must be globally enabled, any nested trap in progress must not carry a higher trap type, and the candidate must differ from the index already recorded. When nothing at all is pending, the index and the request are cleared.

The trap-entry sequencer reads the index and the request flag. Register write ports and timer counters sit outside this block.

Top module: `irq_level_sel`

## Requirements
- R1: The pending vector is the bitwise OR of `ext_lvl` with bits 15..1 of `sw_int`. Bit 0 of `sw_int` (tick match) and bit 16 (system-tick match) are never treated as levels 0 or 16.
- R2: If bit 0 or bit 16 of `sw_int` is set, level 14 is pending.
- R3: When no level is pending (`ext_lvl` and `sw_int` all zero), the next rising edge sets `irq_req` to 0 and `irq_idx` to 0. This happens whatever `int_en` is.
- R4: While `int_en` is 0 and some level is pending, `irq_idx` and `irq_req` keep their values.
- R5: Only levels strictly greater than `proc_lvl` qualify, and the highest qualifying level wins. If no level qualifies, `irq_idx` and `irq_req` keep their values.
- R6: Level 15 is masked by `proc_lvl` like any other level. With `proc_lvl` = 15, nothing qualifies.
- R7: The candidate trap type is 9'h040 OR the winning level, so levels 1..15 give 9'h041..9'h04F. A nonzero `irq_idx` always has this form.
- R8: If `trap_lvl` is nonzero and `cur_tt` is strictly greater than the candidate, nothing is updated. An equal `cur_tt`, or `trap_lvl` = 0, does not block the update.
- R9: When the candidate differs from `irq_idx`, the next edge loads it into `irq_idx` and sets `irq_req` to 1. A candidate equal to `irq_idx` changes nothing.
- R10: `rst` is synchronous and active high. It clears `irq_idx` and `irq_req` on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 16 | External interrupt level requests, bit n = level n |
| sw_int | input | 17 | Software interrupt register: bit 0 tick match, bits 15..1 software levels, bit 16 system-tick match |
| proc_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type saved at the current trap level |
| irq_req | output | 1 | Hard-interrupt request flag |
| irq_idx | output | 9 | Recorded interrupt trap type, 0 when none |

## Verification
The selection is tried in three ways. The first uses single levels from the external vector and from the software register, which shows that both sources reach the same priority logic. The second uses each timer bit alone, which separates folding into level 14 from decoding the bit position. The third uses several levels at once against a range of processor levels, which shows that the mask is strict and that the highest level wins. Nested-trap cases use a saved trap type above, equal to and ignored by a zero trap level, which pins the comparison to strictly greater. Sequences that disable interrupts, repeat an unchanged candidate, and move the index downward tell hold, no-change and update apart.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_SET   = 2'd2
   } irq_act_e;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
   parameter int NLVL      = 16,
   parameter int SW_W      = 17,
   parameter int TICK_BIT  = 0,
   parameter int STICK_BIT = 16,
   parameter int TIMER_LVL = 14
) (
   input  logic [NLVL-1:0] ext_lvl,
   input  logic [SW_W-1:0] sw_int,
   output logic [NLVL-1:0] pend,
   output logic            any_pend
);
   logic timer_hit;
   assign timer_hit = sw_int[TICK_BIT] | sw_int[STICK_BIT];

   for (genvar i = 0; i < NLVL; i++) begin : g_bit
      localparam bit IS_TIMER_POS = (i == TICK_BIT) || (i == STICK_BIT);
      localparam bit IS_FOLD_LVL  = (i == TIMER_LVL);
      logic sw_part;
      if (IS_TIMER_POS) begin : g_mask
         assign sw_part = 1'b0;
      end else begin : g_pass
         assign sw_part = sw_int[i];
      end
      if (IS_FOLD_LVL) begin : g_fold
         assign pend[i] = ext_lvl[i] | sw_part | timer_hit;
      end else begin : g_plain
         assign pend[i] = ext_lvl[i] | sw_part;
      end
   end

   assign any_pend = |pend;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NLVL  = 16,
   parameter int LVL_W = 4
) (
   input  logic [NLVL-1:0]  pend,
   input  logic [LVL_W-1:0] proc_lvl,
   output logic             hit,
   output logic [LVL_W-1:0] win_lvl
);
   logic [NLVL-1:0] qual;

   for (genvar i = 0; i < NLVL; i++) begin : g_qual
      localparam logic [LVL_W:0] LV = (LVL_W+1)'(i);
      assign qual[i] = pend[i] && (LV > {1'b0, proc_lvl});
   end

   always_comb begin
      hit     = 1'b0;
      win_lvl = '0;
      for (int i = 0; i < NLVL; i++) begin
         if (qual[i]) begin
            hit     = 1'b1;
            win_lvl = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_req_ctl.sv
module irq_req_ctl
   import irq_sel_pkg::*;
#(
   parameter int               LVL_W    = 4,
   parameter int               TT_W     = 9,
   parameter int               TL_W     = 3,
   parameter logic [TT_W-1:0]  EXT_BASE = 9'h040
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             any_pend,
   input  logic             int_en,
   input  logic             hit,
   input  logic [LVL_W-1:0] win_lvl,
   input  logic [TL_W-1:0]  trap_lvl,
   input  logic [TT_W-1:0]  cur_tt,
   output logic             req_q,
   output logic [TT_W-1:0]  idx_q
);
   logic [TT_W-1:0] cand;
   logic            blocked;
   irq_act_e        act;

   assign cand    = EXT_BASE | TT_W'(win_lvl);
   assign blocked = (trap_lvl != '0) && (cur_tt > cand);

   always_comb begin
      act = ACT_HOLD;
      if (!any_pend) begin
         act = ACT_CLEAR;
      end else if (int_en && hit && !blocked && (cand != idx_q)) begin
         act = ACT_SET;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= 1'b0;
         idx_q <= '0;
      end else begin
         case (act)
            ACT_CLEAR: begin
               req_q <= 1'b0;
               idx_q <= '0;
            end
            ACT_SET: begin
               req_q <= 1'b1;
               idx_q <= cand;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel #(
   parameter int               NLVL      = 16,
   parameter int               LVL_W     = 4,
   parameter int               SW_W      = 17,
   parameter int               TICK_BIT  = 0,
   parameter int               STICK_BIT = 16,
   parameter int               TIMER_LVL = 14,
   parameter int               TT_W      = 9,
   parameter int               TL_W      = 3,
   parameter logic [TT_W-1:0]  EXT_BASE  = 9'h040
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NLVL-1:0]  ext_lvl,
   input  logic [SW_W-1:0]  sw_int,
   input  logic [LVL_W-1:0] proc_lvl,
   input  logic             int_en,
   input  logic [TL_W-1:0]  trap_lvl,
   input  logic [TT_W-1:0]  cur_tt,
   output logic             irq_req,
   output logic [TT_W-1:0]  irq_idx
);
   if (NLVL != (1 << LVL_W)) begin : g_chk_lvl
      $error("NLVL must equal 2**LVL_W");
   end
   if (TIMER_LVL >= NLVL || TICK_BIT >= SW_W || STICK_BIT >= SW_W) begin : g_chk_pos
      $error("timer bit or fold level out of range");
   end
   if (TT_W <= LVL_W) begin : g_chk_tt
      $error("trap type must be wider than the level number");
   end

   logic [NLVL-1:0]  pend;
   logic             any_pend;
   logic             hit;
   logic [LVL_W-1:0] win_lvl;

   irq_pend_merge #(
      .NLVL(NLVL), .SW_W(SW_W), .TICK_BIT(TICK_BIT),
      .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
   ) u_merge (
      .ext_lvl(ext_lvl), .sw_int(sw_int), .pend(pend), .any_pend(any_pend)
   );

   irq_prio_pick #(.NLVL(NLVL), .LVL_W(LVL_W)) u_pick (
      .pend(pend), .proc_lvl(proc_lvl), .hit(hit), .win_lvl(win_lvl)
   );

   irq_req_ctl #(
      .LVL_W(LVL_W), .TT_W(TT_W), .TL_W(TL_W), .EXT_BASE(EXT_BASE)
   ) u_ctl (
      .clk(clk), .rst(rst), .any_pend(any_pend), .int_en(int_en),
      .hit(hit), .win_lvl(win_lvl), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
      .req_q(irq_req), .idx_q(irq_idx)
   );
endmodule

// File: rtl/irq_level_sel_chk.sv
module irq_level_sel_chk #(
   parameter int               NLVL     = 16,
   parameter int               LVL_W    = 4,
   parameter int               SW_W     = 17,
   parameter int               TT_W     = 9,
   parameter int               TL_W     = 3,
   parameter logic [TT_W-1:0]  EXT_BASE = 9'h040
) (
   input logic             clk,
   input logic             rst,
   input logic [NLVL-1:0]  ext_lvl,
   input logic [SW_W-1:0]  sw_int,
   input logic [LVL_W-1:0] proc_lvl,
   input logic             int_en,
   input logic [TL_W-1:0]  trap_lvl,
   input logic [TT_W-1:0]  cur_tt,
   input logic             irq_req,
   input logic [TT_W-1:0]  irq_idx
);
   localparam logic [TT_W-1:0] TOP_TT = EXT_BASE | TT_W'(NLVL - 1);

   logic none_pend;
   assign none_pend = (ext_lvl == '0) && (sw_int == '0);

   p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      none_pend |=> (irq_idx == '0) && !irq_req);

   p_hold_disabled_r4: assert property (@(posedge clk) disable iff (rst)
      (!int_en && !none_pend) |=> ($stable(irq_idx) && $stable(irq_req)));

   p_above_mask_r5: assert property (@(posedge clk) disable iff (rst)
      ((irq_idx != $past(irq_idx)) && (irq_idx != '0))
         |-> (irq_idx[LVL_W-1:0] > $past(proc_lvl)));

   p_tt_form_r7: assert property (@(posedge clk) disable iff (rst)
      (irq_idx != '0) |-> ((irq_idx[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W])
                           && (irq_idx[LVL_W-1:0] != '0)));

   p_nest_block_r8: assert property (@(posedge clk) disable iff (rst)
      ((trap_lvl != '0) && (cur_tt > TOP_TT) && !none_pend)
         |=> ($stable(irq_idx) && $stable(irq_req)));

   p_set_req_r9: assert property (@(posedge clk) disable iff (rst)
      ((irq_idx != $past(irq_idx)) && (irq_idx != '0)) |-> irq_req);
endmodule

bind irq_level_sel irq_level_sel_chk #(
   .NLVL(NLVL), .LVL_W(LVL_W), .SW_W(SW_W), .TT_W(TT_W),
   .TL_W(TL_W), .EXT_BASE(EXT_BASE)
) u_chk (
   .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .sw_int(sw_int),
   .proc_lvl(proc_lvl), .int_en(int_en), .trap_lvl(trap_lvl),
   .cur_tt(cur_tt), .irq_req(irq_req), .irq_idx(irq_idx)
);

// File: tb/sim_irq_level_sel.sv
`timescale 1ns/1ps
module sim_irq_level_sel;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ext_lvl = '0;
   logic [16:0] sw_int = '0;
   logic [3:0]  proc_lvl = '0;
   logic        int_en = 1'b1;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  cur_tt = '0;
   logic        irq_req;
   logic [8:0]  irq_idx;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_level_sel u0 (
      .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .sw_int(sw_int),
      .proc_lvl(proc_lvl), .int_en(int_en), .trap_lvl(trap_lvl),
      .cur_tt(cur_tt), .irq_req(irq_req), .irq_idx(irq_idx)
   );

   task automatic chk(string tag, logic er, logic [8:0] ei);
      n_run++;
      if (irq_req !== er || irq_idx !== ei) begin
         n_fail++;
         $display("FAIL %s: req=%0b idx=%h expected req=%0b idx=%h",
                  tag, irq_req, irq_idx, er, ei);
      end
   endtask

   task automatic step(logic [15:0] e, logic [16:0] s, logic [3:0] pl,
                       logic en, logic [2:0] tl, logic [8:0] tt);
      @(negedge clk);
      ext_lvl = e; sw_int = s; proc_lvl = pl; int_en = en;
      trap_lvl = tl; cur_tt = tt;
      @(negedge clk);
   endtask

   task automatic clear_all();
      step('0, '0, 4'd0, 1'b1, 3'd0, 9'h000);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      ext_lvl = 16'h8000; sw_int = 17'h1;
      repeat (3) @(negedge clk);
      chk("R10 reset", 1'b0, 9'h000);
      rst = 1'b0;
      clear_all();
      chk("R3 idle after reset", 1'b0, 9'h000);
   endtask

   task automatic t_sources();
      step(16'h0200, '0, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R1 R7 external level 9", 1'b1, 9'h049);
      clear_all();
      chk("R3 cleared", 1'b0, 9'h000);
      step('0, 17'h1000, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R1 software level 12", 1'b1, 9'h04C);
      clear_all();
   endtask

   task automatic t_timers();
      step('0, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R2 tick bit to level 14", 1'b1, 9'h04E);
      clear_all();
      step('0, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R2 system tick to level 14", 1'b1, 9'h04E);
      clear_all();
      step('0, 17'h00001, 4'd14, 1'b1, 3'd0, 9'h000);
      chk("R1 tick bit is not a level of its own", 1'b0, 9'h000);
      clear_all();
   endtask

   task automatic t_priority();
      step(16'h0888, '0, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R5 highest of 3,7,11", 1'b1, 9'h04B);
      clear_all();
      step(16'h0088, '0, 4'd7, 1'b1, 3'd0, 9'h000);
      chk("R5 level equal to mask does not qualify", 1'b0, 9'h000);
      step(16'h0088, '0, 4'd6, 1'b1, 3'd0, 9'h000);
      chk("R5 level 7 above mask 6", 1'b1, 9'h047);
      step(16'h0008, '0, 4'd5, 1'b1, 3'd0, 9'h000);
      chk("R5 no qualifying level holds", 1'b1, 9'h047);
      clear_all();
   endtask

   task automatic t_level15();
      step(16'h8000, '0, 4'd15, 1'b1, 3'd0, 9'h000);
      chk("R6 level 15 masked by 15", 1'b0, 9'h000);
      step(16'h8000, '0, 4'd14, 1'b1, 3'd0, 9'h000);
      chk("R6 level 15 above 14", 1'b1, 9'h04F);
   endtask

   task automatic t_disable();
      step(16'h0020, '0, 4'd0, 1'b0, 3'd0, 9'h000);
      chk("R4 disabled holds index", 1'b1, 9'h04F);
      step(16'h0020, '0, 4'd0, 1'b1, 3'd0, 9'h000);
      chk("R9 new lower candidate loads", 1'b1, 9'h045);
      step('0, '0, 4'd0, 1'b0, 3'd0, 9'h000);
      chk("R3 clears even when disabled", 1'b0, 9'h000);
   endtask

   task automatic t_nested();
      step(16'h0400, '0, 4'd0, 1'b1, 3'd1, 9'h060);
      chk("R8 higher saved trap type blocks", 1'b0, 9'h000);
      step(16'h0400, '0, 4'd0, 1'b1, 3'd1, 9'h04A);
      chk("R8 equal saved trap type allows", 1'b1, 9'h04A);
      clear_all();
      step(16'h0400, '0, 4'd0, 1'b1, 3'd0, 9'h060);
      chk("R8 trap level zero ignores saved type", 1'b1, 9'h04A);
      step(16'h0400, '0, 4'd0, 1'b1, 3'd0, 9'h060);
      chk("R9 same candidate no change", 1'b1, 9'h04A);
      clear_all();
   endtask

   initial begin
      t_reset();
      t_sources();
      t_timers();
      t_priority();
      t_level15();
      t_disable();
      t_nested();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run=%0d expected completion", n_run);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule